// File: doc/BRIEF.md
# Text-Cell Rectangle Blit Engine

This block carries out rectangle operations on a character-cell text buffer kept in a local synchronous memory. It runs one command at a time. A command can copy a rectangle of cells to another place in the buffer, or paint every cell of a rectangle with one character code and one colour pair. A third kind, the glyph run, fills a rectangle in row-major order with character codes taken from a separate byte stream, and it stops when its run length is used up.

Commands arrive on a valid/ready handshake. Each carries the operation, the source and destination cell coordinates, the width, the height, the foreground and background colours, a fill code and a run length. The memory holds one cell per 16-bit word, and the buffer is `VIRT_WIDTH/8` cells wide. When the source and destination of a copy overlap, the engine picks the traversal direction that leaves the moved image intact. A one-cycle `done` pulse ends every command.

Top module: `tcb_engine`

## Requirements
- R1: A written cell word holds the character code in bits 7:0 and the attribute in bits 15:8. The attribute carries the background colour in bits 15:12 and the foreground colour in bits 11:8.
- R2: Cell (x, y) is at word address y*COLS + x, where COLS = VIRT_WIDTH/8.
- R3: A copy with source row greater than destination row, or with equal rows and source column greater than destination column, writes its cells in row-major order, starting at the top-left cell.
- R4: Every other copy starts at the bottom-right cell and steps to lower columns, then to lower rows. An overlapping copy leaves the destination equal to the source image as it was before the command.
- R5: A fill (operation code 1) writes the fill code and attribute to every cell of the rectangle in row-major order, one cell per cycle, so `done` comes w*h cycles after acceptance.
- R6: A glyph run (operation code 2) takes one code per glyph handshake and writes the codes in row-major order. It stops after run-length cells or at the end of the rectangle, whichever comes first. `glyph_ready` is high only while a run is still in progress, and glyphs beyond that point are left unconsumed.
- R7: A copy (operation code 0) reads each source cell and writes it two cycles after the read request. Reads and writes never occur in the same cycle, and the next read comes only after the write cycle, so a copy takes 3*w*h cycles.
- R8: A command with zero width or zero height, a glyph run of length zero, or operation code 3 raises `done` in the first cycle after acceptance and makes no memory access.
- R9: `cmd_ready` is high only while idle. After acceptance it stays low until `done` has been shown, and commands offered during that time are not taken.
- R10: `done` is a single-cycle pulse. It coincides with the last write, by which point every write of the command has been issued, and `cmd_ready` returns in the following cycle.
- R11: A synchronous active-high reset leaves `cmd_ready` high and `done`, `glyph_ready`, `mem_re` and `mem_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken on valid |
| cmd_op | input | 2 | 0 copy, 1 fill, 2 glyph run, 3 no-op |
| cmd_src_x | input | X_W | Source column (copy) |
| cmd_src_y | input | Y_W | Source row (copy) |
| cmd_dst_x | input | X_W | Destination column |
| cmd_dst_y | input | Y_W | Destination row |
| cmd_width | input | W_W | Rectangle width in cells |
| cmd_height | input | H_W | Rectangle height in cells |
| cmd_fg | input | 4 | Foreground colour |
| cmd_bg | input | 4 | Background colour |
| cmd_fill_idx | input | 8 | Character code for fill |
| cmd_run_len | input | LEN_W | Number of glyphs in a run |
| glyph_valid | input | 1 | Glyph code offered |
| glyph_ready | output | 1 | Glyph code taken on valid |
| glyph_idx | input | 8 | Glyph character code |
| mem_addr | output | ADDR_W | Cell word address |
| mem_re | output | 1 | Read request, data one cycle later |
| mem_we | output | 1 | Write request |
| mem_wdata | output | 16 | Cell word to write |
| mem_rdata | input | 16 | Read data from memory |
| done | output | 1 | Command complete pulse |

## Verification
On every cycle the assertions check the memory-port discipline of copies: reads and writes stay exclusive, and each read is followed by a silent cycle and then a write. They also check that an accepted command drops `cmd_ready`, that an idle engine is silent, that `done` lasts one cycle and is followed by readiness, and that each taken glyph becomes a write. Only the scenarios can show that the traversal order matches the relative source and destination positions, that overlapping copies preserve the image, that the words are packed correctly, and that a run stops early and leaves later glyphs in the stream. They also supply the cycle counts of fills and copies.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

  typedef enum logic [1:0] {
    OP_COPY = 2'd0,
    OP_FILL = 2'd1,
    OP_RUN  = 2'd2,
    OP_NONE = 2'd3
  } tcb_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CP_RD,
    ST_CP_WAIT,
    ST_CP_WR,
    ST_FILL,
    ST_RUN,
    ST_DONE
  } tcb_state_e;

  // cell word: attribute {bg, fg} in the upper byte, code in the lower byte
  function automatic logic [15:0] tcb_cell(input logic [7:0] code,
                                           input logic [3:0] fg,
                                           input logic [3:0] bg);
    return {bg, fg, code};
  endfunction

endpackage

// File: rtl/tcb_ptr.sv
// Address stepper: keeps a row base and a cell pointer, moving forward or
// backward by one cell or by one row.
module tcb_ptr #(
  parameter int ADDR_W = 10,
  parameter int COLS   = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] start,
  input  logic              rev,
  input  logic              step_col,
  input  logic              step_row,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] ROW_STEP = ADDR_W'(COLS);
  localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);

  logic [ADDR_W-1:0] row_q, ptr_q, next_row;
  logic              rev_q;

  assign next_row = rev_q ? (row_q - ROW_STEP) : (row_q + ROW_STEP);
  assign addr     = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
      ptr_q <= '0;
      rev_q <= 1'b0;
    end else if (load) begin
      row_q <= start;
      ptr_q <= start;
      rev_q <= rev;
    end else if (step_row) begin
      row_q <= next_row;
      ptr_q <= next_row;
    end else if (step_col) begin
      ptr_q <= rev_q ? (ptr_q - ONE) : (ptr_q + ONE);
    end
  end
endmodule

// File: rtl/tcb_walk.sv
// Rectangle walker: counts columns and rows, flags row end and last cell.
module tcb_walk #(
  parameter int W_W = 6,
  parameter int H_W = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [W_W-1:0] width,
  input  logic [H_W-1:0] height,
  input  logic           adv,
  output logic           row_end,
  output logic           last
);
  logic [W_W-1:0] cx_q, w_q;
  logic [H_W-1:0] cy_q, h_q;

  assign row_end = (cx_q == (w_q - W_W'(1)));
  assign last    = row_end && (cy_q == (h_q - H_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cx_q <= '0;
      cy_q <= '0;
      w_q  <= '0;
      h_q  <= '0;
    end else if (load) begin
      cx_q <= '0;
      cy_q <= '0;
      w_q  <= width;
      h_q  <= height;
    end else if (adv) begin
      if (row_end) begin
        cx_q <= '0;
        cy_q <= cy_q + H_W'(1);
      end else begin
        cx_q <= cx_q + W_W'(1);
      end
    end
  end
endmodule

// File: rtl/tcb_engine.sv
module tcb_engine #(
  parameter  int VIRT_WIDTH = 320,
  parameter  int ROWS       = 25,
  localparam int COLS       = VIRT_WIDTH / 8,
  localparam int CELLS      = COLS * ROWS,
  localparam int ADDR_W     = $clog2(CELLS),
  localparam int X_W        = $clog2(COLS),
  localparam int Y_W        = $clog2(ROWS),
  localparam int W_W        = $clog2(COLS + 1),
  localparam int H_W        = $clog2(ROWS + 1),
  localparam int LEN_W      = $clog2(CELLS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [X_W-1:0]    cmd_src_x,
  input  logic [Y_W-1:0]    cmd_src_y,
  input  logic [X_W-1:0]    cmd_dst_x,
  input  logic [Y_W-1:0]    cmd_dst_y,
  input  logic [W_W-1:0]    cmd_width,
  input  logic [H_W-1:0]    cmd_height,
  input  logic [3:0]        cmd_fg,
  input  logic [3:0]        cmd_bg,
  input  logic [7:0]        cmd_fill_idx,
  input  logic [LEN_W-1:0]  cmd_run_len,
  input  logic              glyph_valid,
  output logic              glyph_ready,
  input  logic [7:0]        glyph_idx,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              done
);
  import tcb_pkg::*;

  tcb_state_e        state_q;
  logic [3:0]        fg_q, bg_q;
  logic [7:0]        fill_q;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       wdata_q;
  logic              re_q, we_q;

  logic accept, empty, copy_rev, take, adv, row_end, last, finish;
  logic [ADDR_W-1:0] src_fwd, src_rev, dst_fwd, dst_rev;
  logic [ADDR_W-1:0] ptr_start [2];
  logic [ADDR_W-1:0] ptr_addr  [2];

  assign cmd_ready   = (state_q == ST_IDLE);
  assign done        = (state_q == ST_DONE);
  assign glyph_ready = (state_q == ST_RUN);
  assign mem_addr    = addr_q;
  assign mem_re      = re_q;
  assign mem_we      = we_q;
  assign mem_wdata   = wdata_q;

  assign accept = cmd_valid && cmd_ready;
  assign empty  = (cmd_width == '0) || (cmd_height == '0) ||
                  (tcb_op_e'(cmd_op) == OP_NONE) ||
                  ((tcb_op_e'(cmd_op) == OP_RUN) && (cmd_run_len == '0));

  // forward only when the source lies below, or level and to the right
  assign copy_rev = (tcb_op_e'(cmd_op) == OP_COPY) &&
                    !((cmd_src_y > cmd_dst_y) ||
                      ((cmd_src_y == cmd_dst_y) && (cmd_src_x > cmd_dst_x)));

  always_comb begin
    src_fwd = ADDR_W'(int'(cmd_src_y) * COLS + int'(cmd_src_x));
    dst_fwd = ADDR_W'(int'(cmd_dst_y) * COLS + int'(cmd_dst_x));
    src_rev = ADDR_W'((int'(cmd_src_y) + int'(cmd_height) - 1) * COLS +
                      int'(cmd_src_x) + int'(cmd_width) - 1);
    dst_rev = ADDR_W'((int'(cmd_dst_y) + int'(cmd_height) - 1) * COLS +
                      int'(cmd_dst_x) + int'(cmd_width) - 1);
  end

  assign ptr_start[0] = copy_rev ? src_rev : src_fwd;
  assign ptr_start[1] = copy_rev ? dst_rev : dst_fwd;

  assign take   = glyph_valid && glyph_ready;
  assign adv    = (state_q == ST_CP_WR) || (state_q == ST_FILL) || take;
  assign finish = adv && (last || ((state_q == ST_RUN) && (len_q == LEN_W'(1))));

  // index 0 walks the source, index 1 the destination
  for (genvar g = 0; g < 2; g++) begin : g_ptr
    tcb_ptr #(.ADDR_W(ADDR_W), .COLS(COLS)) ptr_i (
      .clk      (clk),
      .rst      (rst),
      .load     (accept),
      .start    (ptr_start[g]),
      .rev      (copy_rev),
      .step_col (adv && !row_end),
      .step_row (adv && row_end),
      .addr     (ptr_addr[g])
    );
  end

  tcb_walk #(.W_W(W_W), .H_W(H_W)) walk_i (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .width   (cmd_width),
    .height  (cmd_height),
    .adv     (adv),
    .row_end (row_end),
    .last    (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      fg_q    <= '0;
      bg_q    <= '0;
      fill_q  <= '0;
      len_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      re_q    <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      re_q <= 1'b0;
      we_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            fg_q   <= cmd_fg;
            bg_q   <= cmd_bg;
            fill_q <= cmd_fill_idx;
            len_q  <= cmd_run_len;
            if (empty)                                 state_q <= ST_DONE;
            else if (tcb_op_e'(cmd_op) == OP_COPY)     state_q <= ST_CP_RD;
            else if (tcb_op_e'(cmd_op) == OP_FILL)     state_q <= ST_FILL;
            else                                       state_q <= ST_RUN;
          end
        end
        ST_CP_RD: begin
          re_q    <= 1'b1;
          addr_q  <= ptr_addr[0];
          state_q <= ST_CP_WAIT;
        end
        ST_CP_WAIT: state_q <= ST_CP_WR;
        ST_CP_WR: begin
          we_q    <= 1'b1;
          addr_q  <= ptr_addr[1];
          wdata_q <= mem_rdata;
          state_q <= finish ? ST_DONE : ST_CP_RD;
        end
        ST_FILL: begin
          we_q    <= 1'b1;
          addr_q  <= ptr_addr[1];
          wdata_q <= tcb_cell(fill_q, fg_q, bg_q);
          if (finish) state_q <= ST_DONE;
        end
        ST_RUN: begin
          if (take) begin
            we_q    <= 1'b1;
            addr_q  <= ptr_addr[1];
            wdata_q <= tcb_cell(glyph_idx, fg_q, bg_q);
            len_q   <= len_q - LEN_W'(1);
            if (finish) state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tcb_engine_chk.sv
module tcb_engine_chk (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic glyph_valid,
  input logic glyph_ready,
  input logic mem_re,
  input logic mem_we,
  input logic done
);
  // R7
  rw_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

  // R7
  read_to_write_chk: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> (!mem_re && !mem_we) ##1 mem_we);

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (!mem_re && !mem_we && !glyph_ready && !done));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && cmd_ready));

  // R6
  glyph_write_chk: assert property (@(posedge clk) disable iff (rst)
    (glyph_valid && glyph_ready) |=> mem_we);
endmodule

bind tcb_engine tcb_engine_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .glyph_valid (glyph_valid),
  .glyph_ready (glyph_ready),
  .mem_re      (mem_re),
  .mem_we      (mem_we),
  .done        (done)
);

// File: tb/tcb_engine_tb_top.sv
module tcb_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VW    = 320;
  localparam int NROWS = 25;
  localparam int COLS  = VW / 8;
  localparam int CELLS = COLS * NROWS;
  localparam int ADDR_W = $clog2(CELLS);
  localparam int X_W   = $clog2(COLS);
  localparam int Y_W   = $clog2(NROWS);
  localparam int W_W   = $clog2(COLS + 1);
  localparam int H_W   = $clog2(NROWS + 1);
  localparam int LEN_W = $clog2(CELLS + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [X_W-1:0] cmd_src_x = '0, cmd_dst_x = '0;
  logic [Y_W-1:0] cmd_src_y = '0, cmd_dst_y = '0;
  logic [W_W-1:0] cmd_width = '0;
  logic [H_W-1:0] cmd_height = '0;
  logic [3:0] cmd_fg = '0, cmd_bg = '0;
  logic [7:0] cmd_fill_idx = '0;
  logic [LEN_W-1:0] cmd_run_len = '0;
  logic glyph_valid = 1'b0, glyph_ready;
  logic [7:0] glyph_idx = '0;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_re, mem_we, done;
  logic [15:0] mem_wdata, mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcb_engine #(.VIRT_WIDTH(VW), .ROWS(NROWS)) dut_i (.*);

  // memory model
  logic [15:0] ram  [CELLS];
  logic [15:0] refm [CELLS];
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  int checks = 0, errors = 0;
  typedef struct { int addr; logic [15:0] data; } wr_t;
  wr_t expq[$];
  string cur_tag = "R3";
  int cyc = 0, last_rd_cyc = -10, reads = 0, writes = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the expected write stream
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (mem_re && mem_we) check(0, "R7", "read and write together", 1, 0);
      if (mem_re) begin
        last_rd_cyc = cyc;
        reads++;
      end
      if (mem_we) begin
        writes++;
        if (expq.size() == 0) begin
          check(0, cur_tag, "unexpected write addr", int'(mem_addr), -1);
        end else begin
          check(int'(mem_addr) == expq[0].addr, cur_tag, "write address",
                int'(mem_addr), expq[0].addr);
          check(mem_wdata == expq[0].data, "R1", "write data",
                int'(mem_wdata), int'(expq[0].data));
          void'(expq.pop_front());
        end
        if (cur_tag == "R3" || cur_tag == "R4")
          check(cyc == last_rd_cyc + 2, "R7", "read to write spacing",
                cyc - last_rd_cyc, 2);
      end
    end
  end

  // glyph stream source
  logic [7:0] gq[$];
  bit gap_en = 0, will_take = 0;
  always @(negedge clk) begin
    if (will_take) void'(gq.pop_front());
    glyph_valid = (gq.size() > 0) && !(gap_en && (cyc % 3 == 1));
    glyph_idx   = (gq.size() > 0) ? gq[0] : 8'h00;
    will_take   = glyph_valid && glyph_ready;
  end

  task automatic tick;
    @(negedge clk);
    #1;
  endtask

  function automatic void plan_copy(int sx, int sy, int dx, int dy, int w, int h);
    bit fwd = (sy > dy) || (sy == dy && sx > dx);
    for (int k = 0; k < w * h; k++) begin
      int r = k / w;
      int c = k % w;
      int sa, da;
      wr_t e;
      if (!fwd) begin r = h - 1 - r; c = w - 1 - c; end
      sa = (sy + r) * COLS + sx + c;
      da = (dy + r) * COLS + dx + c;
      e.addr = da; e.data = refm[sa];
      refm[da] = refm[sa];
      expq.push_back(e);
    end
  endfunction

  function automatic void plan_fill(int dx, int dy, int w, int h, int fg, int bg, int code);
    for (int k = 0; k < w * h; k++) begin
      wr_t e;
      e.addr = (dy + k / w) * COLS + dx + k % w;
      e.data = {bg[3:0], fg[3:0], code[7:0]};
      refm[e.addr] = e.data;
      expq.push_back(e);
    end
  endfunction

  function automatic void plan_run(int dx, int dy, int w, int h, int fg, int bg,
                                   int len, int extra);
    int n = (len < w * h) ? len : w * h;
    for (int k = 0; k < len + extra; k++) gq.push_back(8'(8'h60 + k * 3));
    for (int k = 0; k < n; k++) begin
      wr_t e;
      e.addr = (dy + k / w) * COLS + dx + k % w;
      e.data = {bg[3:0], fg[3:0], 8'(8'h60 + k * 3)};
      refm[e.addr] = e.data;
      expq.push_back(e);
    end
  endfunction

  task automatic run_cmd(input int op, input int sx, input int sy, input int dx,
                         input int dy, input int w, input int h, input int fg,
                         input int bg, input int code, input int len,
                         input bit poke, output int lat);
    tick();
    check(cmd_ready == 1'b1, "R9", "ready before command", int'(cmd_ready), 1);
    cmd_op = 2'(op); cmd_src_x = X_W'(sx); cmd_src_y = Y_W'(sy);
    cmd_dst_x = X_W'(dx); cmd_dst_y = Y_W'(dy);
    cmd_width = W_W'(w); cmd_height = H_W'(h);
    cmd_fg = 4'(fg); cmd_bg = 4'(bg); cmd_fill_idx = 8'(code);
    cmd_run_len = LEN_W'(len);
    cmd_valid = 1'b1;
    tick();
    if (poke) begin
      // a second command held on the port while busy must not be taken
      cmd_op = 2'd1; cmd_dst_x = '0; cmd_dst_y = '0;
      cmd_width = W_W'(1); cmd_height = H_W'(1); cmd_fill_idx = 8'hEE;
    end else begin
      cmd_valid = 1'b0;
    end
    check(cmd_ready == 1'b0, "R9", "ready after accept", int'(cmd_ready), 0);
    lat = 0;
    while (!done && lat < 5000) begin
      if (poke && cmd_ready) check(0, "R9", "ready while busy", 1, 0);
      tick();
      lat++;
    end
    cmd_valid = 1'b0;
    check(done == 1'b1, "R10", "done seen", int'(done), 1);
    check(expq.size() == 0, "R10", "writes pending at done", expq.size(), 0);
    tick();
    check(done == 1'b0 && cmd_ready == 1'b1, "R10", "done pulse then ready",
          {int'(done), int'(cmd_ready)}, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat, r0, w0, left;
    for (int i = 0; i < CELLS; i++) begin
      ram[i]  = 16'(i * 16'h0123 + 16'h0a5c);
      refm[i] = ram[i];
    end
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R11 reset state
    check(cmd_ready == 1'b1, "R11", "reset ready", int'(cmd_ready), 1);
    check(!done && !glyph_ready && !mem_re && !mem_we, "R11", "reset outputs quiet",
          {int'(done), int'(glyph_ready), int'(mem_re), int'(mem_we)}, 0);

    // R5 fill, R1 packing
    cur_tag = "R5";
    plan_fill(2, 1, 5, 3, 4'hA, 4'h3, 8'h41);
    run_cmd(1, 0, 0, 2, 1, 5, 3, 4'hA, 4'h3, 8'h41, 0, 1'b0, lat);
    check(lat == 15, "R5", "fill cycles", lat, 15);

    // R2 last cell of the buffer, with a command held during busy (R9)
    cur_tag = "R2";
    plan_fill(COLS - 1, NROWS - 1, 1, 1, 4'h5, 4'hC, 8'h7F);
    run_cmd(1, 0, 0, COLS - 1, NROWS - 1, 1, 1, 4'h5, 4'hC, 8'h7F, 0, 1'b1, lat);

    // R3 forward copy, source below destination
    cur_tag = "R3";
    plan_copy(0, 5, 10, 2, 6, 4);
    run_cmd(0, 0, 5, 10, 2, 6, 4, 0, 0, 0, 0, 1'b0, lat);
    check(lat == 72, "R7", "copy cycles", lat, 72);

    // R3 same row, shift left with overlap
    plan_copy(6, 8, 3, 8, 9, 2);
    run_cmd(0, 6, 8, 3, 8, 9, 2, 0, 0, 0, 0, 1'b0, lat);

    // R4 same row, shift right with overlap
    cur_tag = "R4";
    plan_copy(3, 10, 5, 10, 8, 2);
    run_cmd(0, 3, 10, 5, 10, 8, 2, 0, 0, 0, 0, 1'b0, lat);

    // R4 shift down with overlap
    plan_copy(1, 12, 2, 14, 5, 5);
    run_cmd(0, 1, 12, 2, 14, 5, 5, 0, 0, 0, 0, 1'b0, lat);

    // R4 source equals destination
    plan_copy(20, 3, 20, 3, 3, 2);
    run_cmd(0, 20, 3, 20, 3, 3, 2, 0, 0, 0, 0, 1'b0, lat);

    // R6 run stops at its length, stalled stream, extra glyphs untouched
    cur_tag = "R6";
    gap_en = 1;
    plan_run(30, 20, 4, 3, 4'h2, 4'h9, 7, 3);
    run_cmd(2, 0, 0, 30, 20, 4, 3, 4'h2, 4'h9, 0, 7, 1'b0, lat);
    check(glyph_ready == 1'b0, "R6", "glyph_ready after run", int'(glyph_ready), 0);
    left = gq.size();
    check(left == 3, "R6", "glyphs left after short run", left, 3);
    gq.delete();
    tick(); tick();

    // R6 run stops at rectangle end
    gap_en = 0;
    plan_run(12, 22, 3, 2, 4'hF, 4'h0, 9, 0);
    run_cmd(2, 0, 0, 12, 22, 3, 2, 4'hF, 4'h0, 0, 9, 1'b0, lat);
    left = gq.size();
    check(left == 3, "R6", "glyphs left after full rectangle", left, 3);
    gq.delete();
    tick(); tick();

    // R8 empty commands: no access, done right after accept
    cur_tag = "R8";
    r0 = reads; w0 = writes;
    run_cmd(1, 0, 0, 4, 4, 0, 3, 1, 1, 8'h22, 0, 1'b0, lat);
    check(lat == 0, "R8", "zero width latency", lat, 0);
    run_cmd(0, 1, 1, 9, 9, 4, 0, 0, 0, 0, 0, 1'b0, lat);
    check(lat == 0, "R8", "zero height latency", lat, 0);
    gq.push_back(8'h11);
    run_cmd(2, 0, 0, 5, 5, 2, 2, 1, 1, 0, 0, 1'b0, lat);
    check(lat == 0, "R8", "zero run length latency", lat, 0);
    check(gq.size() == 1, "R8", "glyph not consumed", gq.size(), 1);
    gq.delete();
    run_cmd(3, 0, 0, 5, 5, 2, 2, 1, 1, 8'h33, 4, 1'b0, lat);
    check(lat == 0, "R8", "no-op latency", lat, 0);
    check(reads == r0 && writes == w0, "R8", "memory accesses",
          reads + writes - r0 - w0, 0);

    // R2/R4 full buffer image
    tick(); tick();
    begin
      int bad = 0;
      for (int i = 0; i < CELLS; i++)
        if (ram[i] !== refm[i]) begin
          if (bad < 4) $display("FAIL R2 cell %0d: actual 0x%0h expected 0x%0h",
                                i, ram[i], refm[i]);
          bad++;
        end
      checks++;
      if (bad != 0) errors++;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule